// File: doc/BRIEF.md
# Trigger Throttle and Command Sequencer

The block sits between the trigger decision logic and the trigger broadcast output. It merges one stream of physics triggers with special triggers that it creates itself, and it sends at most one trigger per clock cycle. Each trigger leaves with a 6-bit type word and a 24-bit event number.

Every detector drives a choke line and an error line; each line is already the OR over that detector's boards. When any of these lines rises, the block does not just gate the physics stream. It sends a typed notification trigger (choke-on or error-on) and withholds physics triggers until the lines are low again. It then sends the matching off trigger or triggers, and physics flow resumes. Error outranks choke.

The block also issues three other special triggers. A synchronisation trigger goes out at each of up to 16 burst-relative times held in a table that a write port loads. A calibration trigger answers a calibration request. An end-of-burst trigger follows the burst end. Counters record how often choke and error were raised and how many physics triggers were dropped.

Top module: `trig_throttle_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `trig_vld_o` is 0 and `trig_evt_o`, `choke_cnt_o`, `error_cnt_o` and `drop_cnt_o` are all 0.
- R2: A physics trigger sampled while the block is not throttled and no special trigger is pending leaves on the next clock edge with its word unchanged.
- R3: When the OR of all choke lines is high and no error line is high, the block sends a choke-on trigger (word 0x30) exactly once, on the edge after the first sampled high. It is not in the choked state before this; it enters it after the trigger is sent.
- R4: When any error line is high and the block is not yet in the error state, it sends one error-on trigger (word 0x32) and enters the error state. This holds even when already choked. No choke-on is sent while in the error state or while an error line is high.
- R5: An error-off trigger (0x33) is sent only when all choke and error lines are low. If the block had sent a choke-on, a choke-off trigger (0x31) follows on the next cycle. Physics triggers are accepted again from the cycle after the last off trigger.
- R6: The 16-entry synchronisation table is written through `sync_wr_i` at `sync_addr_i`, and its entries must rise strictly. The burst timestamp is 0 in the cycle after the edge that samples `burst_start_i`, and it rises by 1 per cycle. For the entry equal to timestamp T, the block sends a sync trigger (0x3C) on edge T+2 counted from that start edge, unless higher-priority traffic delays it.
- R7: A calibration request pulse causes one calibration trigger (0x3D). Requests that arrive while one is still waiting merge into it.
- R8: A burst end pulse causes one end-of-burst trigger (0x3E) and stops the timestamp and the sync schedule until the next burst start.
- R9: At most one trigger leaves per cycle. The fixed priority, from highest, is: throttle notification, end-of-burst, calibration, sync, physics. A special trigger that loses stays pending.
- R10: A physics trigger is dropped whenever the block is throttled or a special trigger is sent in its cycle. Each drop adds 1 to `drop_cnt_o`.
- R11: Each trigger carries the current event number, which then rises by 1. A burst start sets the number to 0 for the next trigger.
- R12: `choke_cnt_o` and `error_cnt_o` each rise by 1 on every rising edge of the OR of the choke lines or of the error lines, whatever the throttle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| choke_i | input | N_DET | Choke line per detector |
| error_i | input | N_DET | Error line per detector |
| phys_vld_i | input | 1 | Physics trigger valid |
| phys_word_i | input | 6 | Physics trigger word |
| calib_req_i | input | 1 | Calibration request pulse |
| burst_start_i | input | 1 | Burst start pulse |
| burst_end_i | input | 1 | Burst end pulse |
| sync_wr_i | input | 1 | Sync table write enable |
| sync_addr_i | input | 4 | Sync table entry index |
| sync_time_i | input | TS_W | Sync time to store |
| trig_vld_o | output | 1 | Trigger issued this cycle |
| trig_word_o | output | 6 | Trigger type word |
| trig_evt_o | output | EVT_W | Event number of the trigger |
| choke_cnt_o | output | CNT_W | Choke occurrences |
| error_cnt_o | output | CNT_W | Error occurrences |
| drop_cnt_o | output | CNT_W | Dropped physics triggers |

## Verification
Wrong internal state shows at the ports within one or two cycles. A throttle flag stuck high removes physics triggers from the next cycle and moves the drop counter at once. A pending flag that never clears repeats the same special trigger on every cycle. A sync pointer that slips sends a sync trigger at the wrong timestamp or skips one. An event counter error shows in the number on the very next trigger. A cycle-level bench model compares type, event number and all three counters on every cycle, so any difference is reported in the cycle it first appears.

// File: rtl/ttc_pkg.sv
// Shared codes and types for the trigger throttle and command sequencer.
package ttc_pkg;
    localparam int TW = 6;
    localparam logic [TW-1:0] C_CON  = 6'h30;
    localparam logic [TW-1:0] C_COFF = 6'h31;
    localparam logic [TW-1:0] C_EON  = 6'h32;
    localparam logic [TW-1:0] C_EOFF = 6'h33;
    localparam logic [TW-1:0] C_SYNC = 6'h3C;
    localparam logic [TW-1:0] C_CAL  = 6'h3D;
    localparam logic [TW-1:0] C_EOB  = 6'h3E;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_NOTE, SEL_EOB, SEL_CAL, SEL_SYNC, SEL_PHYS
    } sel_e;
endpackage

// File: rtl/ttc_sync_sched.sv
// Burst timestamp plus sync table. Raises sync_hit_o in the cycle the
// timestamp equals the next table entry. Assumes strictly rising entries.
module ttc_sync_sched #(
    parameter int TS_W   = 16,
    parameter int SYNC_N = 16,
    localparam int IDX_W = $clog2(SYNC_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_start_i,
    input  logic             burst_end_i,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] addr_i,
    input  logic [TS_W-1:0]  time_i,
    output logic             sync_hit_o
);
    localparam logic [IDX_W:0] LAST = (IDX_W+1)'(SYNC_N);

    logic [TS_W-1:0] tbl [SYNC_N];
    logic [TS_W-1:0] ts;
    logic [IDX_W:0]  idx;
    logic            active;

    // One register per table entry, written through the load port.
    for (genvar g = 0; g < SYNC_N; g++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (!rst_n)                             tbl[g] <= '1;
            else if (wr_i && addr_i == IDX_W'(g))   tbl[g] <= time_i;
        end
    end

    assign sync_hit_o = active && (idx != LAST) && (ts == tbl[idx[IDX_W-1:0]]);

    // Timestamp, burst flag and table pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts <= '0; idx <= '0; active <= 1'b0;
        end else if (burst_start_i) begin
            ts <= '0; idx <= '0; active <= 1'b1;
        end else if (burst_end_i) begin
            active <= 1'b0;
        end else if (active) begin
            ts <= ts + TS_W'(1);
            if (sync_hit_o) idx <= idx + (IDX_W+1)'(1);
        end
    end

    // R6: each hit moves the pointer by exactly one entry
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_hit_o && !burst_start_i && !burst_end_i) |=> (idx == $past(idx) + (IDX_W+1)'(1)));
endmodule

// File: rtl/ttc_throttle.sv
// Throttle state from the ORed choke/error lines. Produces at most one
// notification per cycle (always granted by the arbiter) and the hold flag
// that withholds physics triggers. Also counts choke and error occurrences.
module ttc_throttle
    import ttc_pkg::*;
#(
    parameter int N_DET = 4,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DET-1:0]  choke_i,
    input  logic [N_DET-1:0]  error_i,
    output logic              note_vld_o,
    output logic [TW-1:0]     note_code_o,
    output logic              hold_o,
    output logic [CNT_W-1:0]  choke_cnt_o,
    output logic [CNT_W-1:0]  error_cnt_o
);
    logic choke_any, error_any, choke_st, err_st, choke_q, error_q;
    logic need_eon, need_eoff, need_con, need_coff;

    assign choke_any = |choke_i;
    assign error_any = |error_i;
    assign need_eon  = error_any && !err_st;
    assign need_eoff = err_st && !error_any && !choke_any;
    assign need_con  = choke_any && !choke_st && !err_st && !error_any;
    assign need_coff = choke_st && !err_st && !choke_any && !error_any;
    assign hold_o    = choke_st || err_st;

    // Select the single notification due this cycle.
    always_comb begin
        note_vld_o  = need_eon || need_eoff || need_con || need_coff;
        note_code_o = need_eon ? C_EON : need_eoff ? C_EOFF : need_con ? C_CON : C_COFF;
    end

    // Throttle state, updated when a notification goes out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            choke_st <= 1'b0; err_st <= 1'b0;
        end else begin
            if (need_eon)  err_st   <= 1'b1;
            if (need_eoff) err_st   <= 1'b0;
            if (need_con)  choke_st <= 1'b1;
            if (need_coff) choke_st <= 1'b0;
        end
    end

    // Occurrence counters on rising edges of the ORed lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            choke_q <= 1'b0; error_q <= 1'b0;
            choke_cnt_o <= '0; error_cnt_o <= '0;
        end else begin
            choke_q <= choke_any;
            error_q <= error_any;
            choke_cnt_o <= choke_cnt_o + CNT_W'(choke_any && !choke_q);
            error_cnt_o <= error_cnt_o + CNT_W'(error_any && !error_q);
        end
    end

    // R3: after an on-notification physics is held
    a_r3_hold_after_on: assert property (@(posedge clk) disable iff (!rst_n)
        (note_vld_o && (note_code_o == C_CON || note_code_o == C_EON)) |=> hold_o);
    // R4: no choke-on while in the error state
    a_r4_no_con_in_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_st |-> !(note_vld_o && note_code_o == C_CON));
    // R5: error-off only with every line low
    a_r5_eoff_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (note_vld_o && note_code_o == C_EOFF) |-> (!choke_any && !error_any));
endmodule

// File: rtl/ttc_arb.sv
// Pending flags for the end-of-burst, calibration and sync triggers, the
// fixed-priority selection, the registered trigger output, the event number
// and the drop counter.
module ttc_arb
    import ttc_pkg::*;
#(
    parameter int EVT_W = 24,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             note_vld_i,
    input  logic [TW-1:0]    note_code_i,
    input  logic             hold_i,
    input  logic             eob_evt_i,
    input  logic             cal_evt_i,
    input  logic             sync_evt_i,
    input  logic             burst_start_i,
    input  logic             phys_vld_i,
    input  logic [TW-1:0]    phys_word_i,
    output logic             trig_vld_o,
    output logic [TW-1:0]    trig_word_o,
    output logic [EVT_W-1:0] trig_evt_o,
    output logic [CNT_W-1:0] drop_cnt_o
);
    logic eob_p, cal_p, sync_p;
    logic [EVT_W-1:0] evt_cnt;
    sel_e sel;
    logic [TW-1:0] word;

    // Fixed-priority choice of this cycle's trigger.
    always_comb begin
        if (note_vld_i)               begin sel = SEL_NOTE; word = note_code_i; end
        else if (eob_p)               begin sel = SEL_EOB;  word = C_EOB;       end
        else if (cal_p)               begin sel = SEL_CAL;  word = C_CAL;       end
        else if (sync_p)              begin sel = SEL_SYNC; word = C_SYNC;      end
        else if (phys_vld_i && !hold_i) begin sel = SEL_PHYS; word = phys_word_i; end
        else                          begin sel = SEL_NONE; word = '0;          end
    end

    // Pending specials: cleared when granted, set by a new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eob_p <= 1'b0; cal_p <= 1'b0; sync_p <= 1'b0;
        end else begin
            eob_p  <= (eob_p  && sel != SEL_EOB)  || eob_evt_i;
            cal_p  <= (cal_p  && sel != SEL_CAL)  || cal_evt_i;
            sync_p <= (sync_p && sel != SEL_SYNC) || sync_evt_i;
        end
    end

    // Registered output, event number and drop count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_vld_o <= 1'b0; trig_word_o <= '0; trig_evt_o <= '0;
            evt_cnt <= '0; drop_cnt_o <= '0;
        end else begin
            trig_vld_o  <= (sel != SEL_NONE);
            trig_word_o <= word;
            trig_evt_o  <= evt_cnt;
            evt_cnt     <= burst_start_i ? '0 : evt_cnt + EVT_W'(sel != SEL_NONE);
            drop_cnt_o  <= drop_cnt_o + CNT_W'(phys_vld_i && sel != SEL_PHYS);
        end
    end

    // R10: a physics trigger under hold is counted as dropped
    a_r10_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_vld_i && hold_i) |=> (drop_cnt_o == $past(drop_cnt_o) + CNT_W'(1)));
    // R9: a notification always wins the next output slot
    a_r9_note_first: assert property (@(posedge clk) disable iff (!rst_n)
        note_vld_i |=> (trig_vld_o && trig_word_o == $past(note_code_i)));
endmodule

// File: rtl/trig_throttle_seq.sv
// Top: trigger throttle and command sequencer. Wires the throttle state,
// the sync schedule and the output arbiter together.
module trig_throttle_seq
    import ttc_pkg::*;
#(
    parameter int N_DET  = 4,
    parameter int TS_W   = 16,
    parameter int EVT_W  = 24,
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 16,
    localparam int IDX_W = $clog2(SYNC_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DET-1:0] choke_i,
    input  logic [N_DET-1:0] error_i,
    input  logic             phys_vld_i,
    input  logic [5:0]       phys_word_i,
    input  logic             calib_req_i,
    input  logic             burst_start_i,
    input  logic             burst_end_i,
    input  logic             sync_wr_i,
    input  logic [IDX_W-1:0] sync_addr_i,
    input  logic [TS_W-1:0]  sync_time_i,
    output logic             trig_vld_o,
    output logic [5:0]       trig_word_o,
    output logic [EVT_W-1:0] trig_evt_o,
    output logic [CNT_W-1:0] choke_cnt_o,
    output logic [CNT_W-1:0] error_cnt_o,
    output logic [CNT_W-1:0] drop_cnt_o
);
    logic          note_vld, hold, sync_hit;
    logic [TW-1:0] note_code;

    ttc_throttle #(.N_DET(N_DET), .CNT_W(CNT_W)) u_thr (
        .clk(clk), .rst_n(rst_n), .choke_i(choke_i), .error_i(error_i),
        .note_vld_o(note_vld), .note_code_o(note_code), .hold_o(hold),
        .choke_cnt_o(choke_cnt_o), .error_cnt_o(error_cnt_o));

    ttc_sync_sched #(.TS_W(TS_W), .SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .burst_start_i(burst_start_i),
        .burst_end_i(burst_end_i), .wr_i(sync_wr_i), .addr_i(sync_addr_i),
        .time_i(sync_time_i), .sync_hit_o(sync_hit));

    ttc_arb #(.EVT_W(EVT_W), .CNT_W(CNT_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .note_vld_i(note_vld), .note_code_i(note_code),
        .hold_i(hold), .eob_evt_i(burst_end_i), .cal_evt_i(calib_req_i),
        .sync_evt_i(sync_hit), .burst_start_i(burst_start_i),
        .phys_vld_i(phys_vld_i), .phys_word_i(phys_word_i),
        .trig_vld_o(trig_vld_o), .trig_word_o(trig_word_o), .trig_evt_o(trig_evt_o),
        .drop_cnt_o(drop_cnt_o));
endmodule

// File: tb/test_trig_throttle_seq.sv
// Bench: fixed-seed random plus directed stimulus, checked every cycle
// against a requirement-level model kept in bench tasks.
module test_trig_throttle_seq;
    localparam int N_DET = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_DET-1:0] choke = '0, error = '0;
    logic phys_vld = 1'b0, calib = 1'b0, bstart = 1'b0, bend = 1'b0, swr = 1'b0;
    logic [5:0] pword = '0;
    logic [3:0] saddr = '0;
    logic [15:0] stime = '0;
    logic trig_vld;
    logic [5:0] trig_word;
    logic [23:0] trig_evt;
    logic [15:0] ccnt, ecnt, dcnt;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trig_throttle_seq i_trig_throttle_seq (
        .clk(clk), .rst_n(rst_n), .choke_i(choke), .error_i(error),
        .phys_vld_i(phys_vld), .phys_word_i(pword), .calib_req_i(calib),
        .burst_start_i(bstart), .burst_end_i(bend), .sync_wr_i(swr),
        .sync_addr_i(saddr), .sync_time_i(stime), .trig_vld_o(trig_vld),
        .trig_word_o(trig_word), .trig_evt_o(trig_evt), .choke_cnt_o(ccnt),
        .error_cnt_o(ecnt), .drop_cnt_o(dcnt));

    // Model state
    bit m_cst, m_est, m_cq, m_eq, m_eobp, m_calp, m_syncp, m_act;
    logic [15:0] m_ts, m_tbl [16];
    int m_idx;
    logic [23:0] m_evt;
    logic [15:0] m_cc, m_ec, m_dc;
    bit x_vld; logic [5:0] x_word; logic [23:0] x_evt; string x_tag;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(logic [5:0] w, bit phys);
        if (phys) return "R2";
        case (w)
            6'h30: return "R3";
            6'h32: return "R4";
            6'h31, 6'h33: return "R5";
            6'h3C: return "R6";
            6'h3D: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic model_reset();
        m_cst = 0; m_est = 0; m_cq = 0; m_eq = 0; m_eobp = 0; m_calp = 0; m_syncp = 0;
        m_act = 0; m_ts = 0; m_idx = 0; m_evt = 0; m_cc = 0; m_ec = 0; m_dc = 0;
        for (int i = 0; i < 16; i++) m_tbl[i] = '1;
    endtask

    // Requirement-level expectation for the edge that samples current inputs.
    task automatic model_cycle();
        bit ca, ea, hold, hit, note, g_eob, g_cal, g_sync, g_phys;
        logic [5:0] nc;
        ca = |choke; ea = |error; hold = m_cst || m_est;
        note = 1;
        if (ea && !m_est) nc = 6'h32;                                  // R4
        else if (m_est && !ea && !ca) nc = 6'h33;                      // R5
        else if (ca && !m_cst && !m_est && !ea) nc = 6'h30;            // R3
        else if (m_cst && !m_est && !ca && !ea) nc = 6'h31;            // R5
        else note = 0;
        hit = m_act && m_idx < 16 && m_ts == m_tbl[m_idx];
        g_eob = !note && m_eobp;
        g_cal = !note && !m_eobp && m_calp;
        g_sync = !note && !m_eobp && !m_calp && m_syncp;
        g_phys = !note && !m_eobp && !m_calp && !m_syncp && phys_vld && !hold;
        x_vld = note || g_eob || g_cal || g_sync || g_phys;
        x_word = note ? nc : g_eob ? 6'h3E : g_cal ? 6'h3D : g_sync ? 6'h3C : pword;
        x_tag = x_vld ? tag_of(x_word, g_phys) : "R9";
        x_evt = m_evt;
        m_evt = bstart ? 24'd0 : m_evt + 24'(x_vld);
        if (phys_vld && !g_phys) m_dc++;
        m_eobp = (m_eobp && !g_eob) || bend;
        m_calp = (m_calp && !g_cal) || calib;
        m_syncp = (m_syncp && !g_sync) || hit;
        if (ca && !m_cq) m_cc++;
        if (ea && !m_eq) m_ec++;
        m_cq = ca; m_eq = ea;
        if (note && nc == 6'h32) m_est = 1;
        if (note && nc == 6'h33) m_est = 0;
        if (note && nc == 6'h30) m_cst = 1;
        if (note && nc == 6'h31) m_cst = 0;
        if (bstart) begin m_ts = 0; m_idx = 0; m_act = 1; end
        else if (bend) m_act = 0;
        else if (m_act) begin m_ts++; if (hit) m_idx++; end
        if (swr) m_tbl[saddr] = stime;
    endtask

    // One clock: predict, let the edge pass, compare at the falling edge.
    task automatic cyc();
        model_cycle();
        @(negedge clk);
        chk(x_tag, 32'(trig_vld), 32'(x_vld));
        if (x_vld) begin
            chk(x_tag, 32'(trig_word), 32'(x_word));
            chk("R11", 32'(trig_evt), 32'(x_evt));
        end
        chk("R12", 32'(ccnt), 32'(m_cc));
        chk("R12", 32'(ecnt), 32'(m_ec));
        chk("R10", 32'(dcnt), 32'(m_dc));
        {calib, bstart, bend, swr} = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", 32'(trig_vld), 0);
        chk("R1", 32'(trig_evt), 0);
        chk("R1", 32'(ccnt) + 32'(ecnt) + 32'(dcnt), 0);
        rst_n = 1'b1;
        // R6: load the sync table, first gaps of one cycle, then random
        begin
            logic [15:0] t = 16'd4;
            for (int i = 0; i < 16; i++) begin
                swr = 1; saddr = 4'(i); stime = t; cyc();
                t = t + ((i < 2) ? 16'd1 : 16'(1 + $urandom % 25));
            end
        end
        // Directed: burst start, physics stream, then choke then error while choked
        bstart = 1; cyc();
        phys_vld = 1; pword = 6'h05; idle(3);
        choke[2] = 1; idle(3);                     // R3 choke-on, hold
        error[0] = 1; idle(3);                     // R4 error-on while choked
        error[0] = 0; idle(2);                     // choke still high: no off yet
        choke[2] = 0; idle(3);                     // R5 error-off then choke-off
        // Directed: error alone, choke raised during error
        error[3] = 1; idle(2); choke[1] = 1; idle(2);
        error[3] = 0; idle(2); choke[1] = 0; idle(3);
        // Directed: calibration and end-of-burst colliding with physics (R7, R8, R9)
        calib = 1; bend = 1; cyc(); calib = 1; idle(4);
        phys_vld = 0; idle(2);
        // Random phase
        bstart = 1; cyc();
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 40 == 0) choke[$urandom % N_DET] ^= 1'b1;
            if ($urandom % 90 == 0) error[$urandom % N_DET] ^= 1'b1;
            phys_vld = ($urandom % 2) == 0;
            pword = 6'($urandom);
            calib = ($urandom % 30) == 0;
            bstart = ($urandom % 500) == 0;
            bend = !bstart && ($urandom % 400) == 0;
            cyc();
        end
        choke = '0; error = '0; phys_vld = 0; idle(5);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule